// File: doc/BRIEF.md
# GPIO Interrupt Detect and Aggregate

This block turns synchronised GPIO input levels into per-pin interrupt events and combines them into one host interrupt line. Each pin carries two configuration bits, a trigger-kind bit (edge or level) and a polarity-invert bit. Together they choose one of four trigger modes. An event sets the pin's bit in a banked status word. Software clears status bits by writing ones, and a banked enable word decides which status bits reach the combined interrupt.

Pins are grouped into banks of `BANK_W` bits. Bank b holds pins b*BANK_W to b*BANK_W+BANK_W-1, and bit i of a bank word is pin b*BANK_W+i. The last bank may be partly filled, and its unused bits always read 0. Software is expected to clear a status bit before it services the pin. An edge that arrives after that clear therefore sets the bit again and is not lost. The configuration storage and pad logic sit outside this block and feed it through plain per-pin vectors.

Top module: `gpio_irq_aggr`

## Requirements
- R1: With trigger-kind 0 and invert 0, a pin raises its status bit on the clock edge where its level is 1 and the level seen at the previous edge was 0.
- R2: With trigger-kind 0 and invert 1, a pin raises its status bit on the clock edge where its level is 0 and the level seen at the previous edge was 1.
- R3: With trigger-kind 1 and invert 0, a pin sets its status bit on every edge where its level is 0. A write-1 clear only takes effect once the level is 1.
- R4: With trigger-kind 1 and invert 1, a pin sets its status bit on every edge where its level is 1.
- R5: A status write strobe for bank b clears each bit of that bank whose `wr_word` bit is 1. Bits written with 0 keep their value, and writing all ones clears the whole bank.
- R6: When a clear and a new event hit the same status bit on the same edge, the bit stays 1.
- R7: An enable write strobe for bank b loads `wr_word` into that bank's enable word. Writing 0 masks every pin of the bank.
- R8: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit set. Status bits are set whether or not the pin is enabled.
- R9: A pin with `sense_off` at 1 or `gpio_mode` at 0 produces no events.
- R10: After reset, all status and enable bits are 0 and `irq_out` is 0. On the first edge after reset is released no event is produced, even for a pin that is already high in a rising mode.
- R11: Status and enable bits at pin positions at or above `NUM_PINS` in the last bank read 0 after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronised input level per pin |
| trig_kind | input | NUM_PINS | Trigger kind per pin: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Polarity invert per pin |
| sense_off | input | NUM_PINS | 1 disables input sensing for the pin |
| gpio_mode | input | NUM_PINS | 1 when the pin is used as a GPIO |
| stat_wr_stb | input | NUM_BANKS | Per-bank write strobe for the status word (write 1 to clear) |
| en_wr_stb | input | NUM_BANKS | Per-bank write strobe for the enable word |
| wr_word | input | BANK_W | Write data shared by all strobes |
| stat_bits | output | NUM_PINS | Status bits of all pins |
| en_bits | output | NUM_PINS | Enable bits of all pins |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench targets the same-edge collision of a clear with a new edge. A design that lets the clear win would drop that edge, and the collided bit would read 0. It holds a level-low pin active through a clear, where a design that treats levels as latched edges would let the bit go to 0. It also checks a pin that is high when reset is released. A design that does not prime its history register would report a false rising edge on the first cycle. Masking a whole bank by writing 0, partial clears with mixed ones and zeros, and sensing-disabled pins that still toggle round out the directed cases. A long random run follows, with its expected values coming from an independent model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // trigger mode as {kind, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_mode_e;

  // one pin's hit test: cur/prv are raw levels
  function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prv);
    logic hit;
    unique case (mode)
      TRIG_RISE: hit = cur & ~prv;
      TRIG_FALL: hit = ~cur & prv;
      TRIG_LOW:  hit = ~cur;
      default:   hit = cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 94
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_lvl,
  input  logic [N-1:0] trig_kind,
  input  logic [N-1:0] trig_inv,
  input  logic [N-1:0] sense_off,
  input  logic [N-1:0] gpio_mode,
  output logic [N-1:0] evt
);

  logic [N-1:0] prev_q, prev_d;
  logic         primed_q, primed_d;

  // next state
  always_comb begin
    prev_d   = pin_lvl;
    primed_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  // per-pin event decode
  for (genvar p = 0; p < N; p++) begin : g_pin
    trig_mode_e mode;
    assign mode   = trig_mode_e'({trig_kind[p], trig_inv[p]});
    assign evt[p] = primed_q & gpio_mode[p] & ~sense_off[p]
                  & trig_hit(mode, pin_lvl[p], prev_q[p]);
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W     = 32,
  parameter int VALID = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         stat_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wr_word,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] en_q,
  output logic         pend
);

  logic [W-1:0] stat_d, en_d, mask;

  always_comb begin
    for (int i = 0; i < W; i++) mask[i] = (i < VALID);
  end

  // next state: clear first, then new events win
  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = stat_d & ~wr_word;
    stat_d = (stat_d | evt) & mask;
    en_d   = en_q;
    if (en_wr) en_d = wr_word & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign pend = |(stat_q & en_q);

  // R5
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & $past(wr_word) & ~$past(evt)) == '0));

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R7
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == ($past(wr_word) & mask)));

  // R5
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (((stat_q ^ $past(stat_q)) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr #(
  parameter int NUM_PINS  = 94,
  parameter int BANK_W    = 32,
  parameter int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pin_lvl,
  input  logic [NUM_PINS-1:0]  trig_kind,
  input  logic [NUM_PINS-1:0]  trig_inv,
  input  logic [NUM_PINS-1:0]  sense_off,
  input  logic [NUM_PINS-1:0]  gpio_mode,
  input  logic [NUM_BANKS-1:0] stat_wr_stb,
  input  logic [NUM_BANKS-1:0] en_wr_stb,
  input  logic [BANK_W-1:0]    wr_word,
  output logic [NUM_PINS-1:0]  stat_bits,
  output logic [NUM_PINS-1:0]  en_bits,
  output logic                 irq_out
);

  localparam int PAD_W = NUM_BANKS * BANK_W;

  logic [NUM_PINS-1:0]  evt;
  logic [PAD_W-1:0]     evt_pad, stat_pad, en_pad;
  logic [NUM_BANKS-1:0] bank_pend;

  gpio_irq_detect #(.N(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .trig_kind (trig_kind),
    .trig_inv  (trig_inv),
    .sense_off (sense_off),
    .gpio_mode (gpio_mode),
    .evt       (evt)
  );

  always_comb begin
    evt_pad = '0;
    evt_pad[NUM_PINS-1:0] = evt;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LEFT  = NUM_PINS - b * BANK_W;
    localparam int VALID = (LEFT > BANK_W) ? BANK_W : LEFT;
    gpio_irq_bank #(.W(BANK_W), .VALID(VALID)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_pad[b*BANK_W +: BANK_W]),
      .stat_wr (stat_wr_stb[b]),
      .en_wr   (en_wr_stb[b]),
      .wr_word (wr_word),
      .stat_q  (stat_pad[b*BANK_W +: BANK_W]),
      .en_q    (en_pad[b*BANK_W +: BANK_W]),
      .pend    (bank_pend[b])
    );
  end

  assign stat_bits = stat_pad[NUM_PINS-1:0];
  assign en_bits   = en_pad[NUM_PINS-1:0];
  assign irq_out   = |bank_pend;

  // R9
  no_evt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_bits & ~$past(stat_bits) & $past(sense_off | ~gpio_mode)) == '0));

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((stat_bits & en_bits) != '0));

endmodule

// File: tb/gpio_irq_aggr_test.sv
`timescale 1ns/1ps
module gpio_irq_aggr_test;

  localparam int NP = 94;
  localparam int BW = 32;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_lvl, trig_kind, trig_inv, sense_off, gpio_mode;
  logic [NB-1:0] stat_wr_stb, en_wr_stb;
  logic [BW-1:0] wr_word;
  logic [NP-1:0] stat_bits, en_bits;
  logic          irq_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // independent model state
  logic [NP-1:0] m_prev, m_stat, m_en;
  logic          m_primed;

  always #2 clk = ~clk;

  gpio_irq_aggr uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_kind(trig_kind),
    .trig_inv(trig_inv), .sense_off(sense_off), .gpio_mode(gpio_mode),
    .stat_wr_stb(stat_wr_stb), .en_wr_stb(en_wr_stb), .wr_word(wr_word),
    .stat_bits(stat_bits), .en_bits(en_bits), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] model_evt();
    logic [NP-1:0] e;
    for (int p = 0; p < NP; p++) begin
      logic hit;
      if (!trig_kind[p]) hit = trig_inv[p] ? (!pin_lvl[p] && m_prev[p]) : (pin_lvl[p] && !m_prev[p]);
      else               hit = (pin_lvl[p] == trig_inv[p]);
      e[p] = m_primed && gpio_mode[p] && !sense_off[p] && hit;
    end
    return e;
  endfunction

  // one clock: model update, edge, compare, strobes dropped
  task automatic tick(string tag);
    logic [NP-1:0] e, clr, nen;
    e = model_evt();
    clr = '0;
    nen = m_en;
    for (int p = 0; p < NP; p++) begin
      if (stat_wr_stb[p/BW]) clr[p] = wr_word[p%BW];
      if (en_wr_stb[p/BW])   nen[p] = wr_word[p%BW];
    end
    @(posedge clk);
    #1;
    m_stat   = (m_stat & ~clr) | e;
    m_en     = nen;
    m_prev   = pin_lvl;
    m_primed = 1'b1;
    chk({tag, " stat"}, 128'(stat_bits), 128'(m_stat));
    chk({tag, " en"},   128'(en_bits),   128'(m_en));
    chk({tag, " irq"},  128'(irq_out),   128'((m_stat & m_en) != '0));
    stat_wr_stb = '0;
    en_wr_stb   = '0;
  endtask

  task automatic set_mode(int p, logic kind, logic inv);
    trig_kind[p] = kind; trig_inv[p] = inv;
    gpio_mode[p] = 1'b1; sense_off[p] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    pin_lvl = '0; trig_kind = '0; trig_inv = '0; sense_off = '0; gpio_mode = '0;
    stat_wr_stb = '0; en_wr_stb = '0; wr_word = '0;
    m_prev = '0; m_stat = '0; m_en = '0; m_primed = 1'b0;
    // R10: pin 5 rising mode, already high during reset
    set_mode(5, 1'b0, 1'b0);
    pin_lvl[5] = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset stat", 128'(stat_bits), 128'(0));
    chk("R10 reset irq",  128'(irq_out),   128'(0));
    rst_n = 1'b1;
    tick("R10 first edge");
    chk("R10 no false edge", 128'(stat_bits[5]), 128'(0));
    pin_lvl[5] = 1'b0; tick("R1 low");
    // R8: status sets while disabled, irq stays low
    pin_lvl[5] = 1'b1; tick("R1 rise");
    chk("R1 pin5 set", 128'(stat_bits[5]), 128'(1));
    chk("R8 no irq while masked", 128'(irq_out), 128'(0));
    wr_word = 32'h0000_0020; en_wr_stb = 3'b001; tick("R7 enable bank0");
    chk("R8 irq on", 128'(irq_out), 128'(1));
    // R6: clear and new rising edge on same cycle
    pin_lvl[5] = 1'b0; wr_word = 32'h20; stat_wr_stb = 3'b001; tick("R5 clear");
    chk("R5 pin5 cleared", 128'(stat_bits[5]), 128'(0));
    pin_lvl[5] = 1'b1; tick("R1 set again");
    pin_lvl[5] = 1'b0; tick("R1 fall ignored");
    pin_lvl[5] = 1'b1; wr_word = 32'h20; stat_wr_stb = 3'b001; tick("R6 collide");
    chk("R6 event wins", 128'(stat_bits[5]), 128'(1));
    // R2: falling on pin 40
    set_mode(40, 1'b0, 1'b1); pin_lvl[40] = 1'b1; tick("R2 high");
    pin_lvl[40] = 1'b0; tick("R2 fall");
    chk("R2 pin40 set", 128'(stat_bits[40]), 128'(1));
    // R3: level low pin 70, clear while active does not stick
    pin_lvl[70] = 1'b1; set_mode(70, 1'b1, 1'b0); tick("R3 idle");
    chk("R3 idle clear", 128'(stat_bits[70]), 128'(0));
    pin_lvl[70] = 1'b0; tick("R3 active");
    wr_word = 32'h40; stat_wr_stb = 3'b100; tick("R3 clear while low");
    chk("R3 still set", 128'(stat_bits[70]), 128'(1));
    pin_lvl[70] = 1'b1; tick("R3 release");
    wr_word = 32'h40; stat_wr_stb = 3'b100; tick("R3 clear after release");
    chk("R3 cleared", 128'(stat_bits[70]), 128'(0));
    // R4: level high pin 93
    set_mode(93, 1'b1, 1'b1); pin_lvl[93] = 1'b1; tick("R4 active");
    chk("R4 pin93 set", 128'(stat_bits[93]), 128'(1));
    // R9: sensing off and non-GPIO pins toggle without events
    trig_kind[10] = 1'b1; trig_inv[10] = 1'b1; gpio_mode[10] = 1'b1; sense_off[10] = 1'b1;
    trig_kind[11] = 1'b1; trig_inv[11] = 1'b0; gpio_mode[11] = 1'b0;
    pin_lvl[10] = 1'b1; tick("R9 toggle");
    chk("R9 no events", 128'(stat_bits[11:10]), 128'(0));
    // R5 partial clear: bits written 0 unchanged
    wr_word = 32'h0; stat_wr_stb = 3'b111; tick("R5 zero write");
    // R11: all ones into last bank
    pin_lvl[93] = 1'b0;
    wr_word = 32'hFFFF_FFFF; en_wr_stb = 3'b100; stat_wr_stb = 3'b110; tick("R11 all ones");
    chk("R11 last bank en", 128'(en_bits[93:64]), 128'(30'h3FFF_FFFF));
    chk("R5 bank2 clear", 128'(stat_bits[93:64]), 128'(0));
    // R7: mask bank0 with 0
    wr_word = 32'h0; en_wr_stb = 3'b001; tick("R7 mask bank0");
    chk("R7 bank0 masked", 128'(en_bits[31:0]), 128'(0));
    // random phase
    for (int ph = 0; ph < 40; ph++) begin
      r = {$urandom(), $urandom(), $urandom()}; trig_kind = r[NP-1:0];
      r = {$urandom(), $urandom(), $urandom()}; trig_inv  = r[NP-1:0];
      r = {$urandom(), $urandom(), $urandom()}; gpio_mode = r[NP-1:0] | {$urandom(), $urandom(), $urandom()};
      r = {$urandom(), $urandom(), $urandom()}; sense_off = r[NP-1:0] & {$urandom(), $urandom(), $urandom()};
      for (int c = 0; c < 50; c++) begin
        r = {$urandom(), $urandom(), $urandom()} & {$urandom(), $urandom(), $urandom()}
          & {$urandom(), $urandom(), $urandom()};
        pin_lvl = pin_lvl ^ r[NP-1:0];
        if ($urandom_range(3) == 0) begin
          wr_word = $urandom();
          if ($urandom_range(4) == 0) wr_word = 32'hFFFF_FFFF;
          stat_wr_stb = NB'($urandom());
          en_wr_stb   = NB'($urandom_range(7) == 0 ? $urandom() : 0);
        end
        tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 R11 random");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule